// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake-Up Controller

This block sequences a radio receiver for low average power. A slow timebase tick, one system-clock pulse per period of a 32.768 kHz reference, drives a period counter. At every period boundary the block switches the receiver on for a short listen window. If the front end reports a preamble and then a sync word inside that window, the block holds the receiver on for a further full window so that the packet can be received. Otherwise it drops the receiver back to sleep until the next boundary.

A single exponent `rExp` scales both timings. The wake period is `4 * mant * 2^rExp` ticks. The window, which is used both for listening and for the receive extension, is `ldc * 4 * 2^rExp` ticks, or that many ticks divided by 32.768 milliseconds. The period counter runs without pause, so an extension never shifts the wake grid. A boundary that falls while the receiver is still busy is dropped and is not queued.

Top module: `rxwake_top`

## Requirements
- R1: With `enable` high and `mant` nonzero, a period boundary occurs on every P-th tick after enable, where P = 4 * mant * 2^rExp. From sleep, a boundary switches `rxEnable` to 1 and `state` to LISTEN, and both are visible on the clock after the boundary tick.
- R2: The listen window lasts W = ldc * 4 * 2^rExp ticks. If no sync is accepted, the block returns to SLEEP on the W-th tick after the wake and stays there until the next boundary.
- R3: A sync pulse is accepted only if `preambleValid` was seen during the same wake, earlier or in the same cycle. An accepted sync moves the block to RECEIVE and restarts a full W-tick window from that cycle. A sync pulse with no preamble leaves the state unchanged.
- R4: `rExp` scales the period and the window by the same power of two.
- R5: The period counter keeps running through LISTEN and RECEIVE. A boundary that occurs while the block is not in SLEEP is skipped and is not carried forward.
- R6: If `ldc` is 0 or `mant` is 0, `rxEnable` never rises.
- R7: While `enable` is low, the block is in SLEEP one clock later, with `rxEnable` at 0. Both counters restart from zero, so the first boundary comes P ticks after `enable` rises again.
- R8: `wakePulse` is high for exactly one clock after each period boundary. This includes boundaries that are skipped.
- R9: `rxEnable` comes from a register and equals `state != SLEEP`. The `state` encoding is SLEEP = 0, LISTEN = 1, RECEIVE = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe per slow timebase period |
| enable | input | 1 | Duty-cycle operation enable |
| rExp | input | 3 | Shared exponent for period and window |
| mant | input | 16 | Period mantissa |
| ldc | input | 8 | Window duration field |
| preambleValid | input | 1 | Preamble detected by the demodulator |
| syncValid | input | 1 | Sync word detected by the demodulator |
| rxEnable | output | 1 | Receiver power enable |
| wakePulse | output | 1 | One-clock pulse at each period boundary |
| state | output | 2 | Current state: 0 SLEEP, 1 LISTEN, 2 RECEIVE |

## Verification
Every output changes one clock after the edge where its cause is sampled. A boundary or window-end tick updates `rxEnable`, `state` and `wakePulse` one clock later. An accepted sync, or a low `enable`, updates `state` one clock later. The bench changes inputs on falling edges and holds each tick for exactly one rising edge. It samples on the falling edge that follows, which is the first point where the registered result can be seen. Timing checks count ticks from a known restart, so an off-by-one in the period or window length shows up as a wrong state on a specific tick.

// File: rtl/rxwake_pkg.sv
package rxwake_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_LISTEN  = 2'd1,
    ST_RECEIVE = 2'd2
  } wakeState_e;

  typedef struct packed {
    logic clrPeriod;
    logic clrWindow;
  } dpStrobe_t;
endpackage

// File: rtl/rxwake_tickcnt.sv
module rxwake_tickcnt #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] count;

  // A zero limit never produces a hit. A count past the limit after a
  // config change still ends the interval.
  assign hit = tick && (limit != '0) && (count >= limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       count <= '0;
    else if (clr)    count <= '0;
    else if (tick)   count <= hit ? '0 : count + CNT_W'(1);
  end
endmodule

// File: rtl/rxwake_timer.sv
module rxwake_timer
  import rxwake_pkg::*;
#(
  parameter int EXP_W  = 3,
  parameter int MANT_W = 16,
  parameter int LDC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [EXP_W-1:0]  rExp,
  input  logic [MANT_W-1:0] mant,
  input  logic [LDC_W-1:0]  ldc,
  input  dpStrobe_t         strobe,
  output logic              periodHit,
  output logic              windowHit,
  output logic              ldcZero
);
  localparam int SHIFT_MAX = (1 << EXP_W) - 1;
  localparam int BASE_W    = (MANT_W > LDC_W) ? MANT_W : LDC_W;
  localparam int CNT_W     = BASE_W + 2 + SHIFT_MAX;

  logic [CNT_W-1:0] lenArr [2];
  logic             clrArr [2];
  logic             hitArr [2];

  assign lenArr[0] = {{(CNT_W-MANT_W-2){1'b0}}, mant, 2'b00} << rExp;
  assign lenArr[1] = {{(CNT_W-LDC_W-2){1'b0}}, ldc, 2'b00} << rExp;
  assign clrArr[0] = strobe.clrPeriod;
  assign clrArr[1] = strobe.clrWindow;

  // Index 0 is the period counter and index 1 is the window counter.
  for (genvar gi = 0; gi < 2; gi++) begin : g_cnt
    rxwake_tickcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .tick  (tick),
      .clr   (clrArr[gi]),
      .limit (lenArr[gi]),
      .hit   (hitArr[gi])
    );
  end

  assign periodHit = hitArr[0];
  assign windowHit = hitArr[1];
  assign ldcZero   = (ldc == '0);
endmodule

// File: rtl/rxwake_ctrl.sv
module rxwake_ctrl
  import rxwake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       ldcZero,
  input  logic       periodHit,
  input  logic       windowHit,
  input  logic       preambleValid,
  input  logic       syncValid,
  output dpStrobe_t  strobe,
  output logic       rxEnable,
  output logic       wakePulse,
  output logic [1:0] stateOut
);
  wakeState_e state, nxtState;
  logic       preSeen;
  logic       syncAccept;

  always_comb begin
    nxtState   = state;
    syncAccept = 1'b0;
    unique case (state)
      ST_SLEEP:   if (periodHit && !ldcZero) nxtState = ST_LISTEN;
      ST_LISTEN: begin
        if (syncValid && (preSeen || preambleValid)) begin
          nxtState   = ST_RECEIVE;
          syncAccept = 1'b1;
        end else if (windowHit) begin
          nxtState = ST_SLEEP;
        end
      end
      ST_RECEIVE: if (windowHit) nxtState = ST_SLEEP;
      default:    nxtState = ST_SLEEP;
    endcase
    if (!enable) nxtState = ST_SLEEP;
  end

  always_comb begin
    strobe.clrPeriod = !enable;
    strobe.clrWindow = !enable || (state == ST_SLEEP) || syncAccept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_SLEEP;
      rxEnable  <= 1'b0;
      wakePulse <= 1'b0;
      preSeen   <= 1'b0;
    end else begin
      state     <= nxtState;
      rxEnable  <= (nxtState != ST_SLEEP);
      wakePulse <= enable && periodHit;
      if (nxtState != ST_LISTEN) preSeen <= 1'b0;
      else if (preambleValid)    preSeen <= 1'b1;
    end
  end

  assign stateOut = state;
endmodule

// File: rtl/rxwake_top.sv
module rxwake_top
  import rxwake_pkg::*;
#(
  parameter int EXP_W  = 3,
  parameter int MANT_W = 16,
  parameter int LDC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              enable,
  input  logic [EXP_W-1:0]  rExp,
  input  logic [MANT_W-1:0] mant,
  input  logic [LDC_W-1:0]  ldc,
  input  logic              preambleValid,
  input  logic              syncValid,
  output logic              rxEnable,
  output logic              wakePulse,
  output logic [1:0]        state
);
  dpStrobe_t strobe;
  logic      periodHit, windowHit, ldcZero;

  rxwake_timer #(.EXP_W(EXP_W), .MANT_W(MANT_W), .LDC_W(LDC_W)) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .rExp      (rExp),
    .mant      (mant),
    .ldc       (ldc),
    .strobe    (strobe),
    .periodHit (periodHit),
    .windowHit (windowHit),
    .ldcZero   (ldcZero)
  );

  rxwake_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .ldcZero       (ldcZero),
    .periodHit     (periodHit),
    .windowHit     (windowHit),
    .preambleValid (preambleValid),
    .syncValid     (syncValid),
    .strobe        (strobe),
    .rxEnable      (rxEnable),
    .wakePulse     (wakePulse),
    .stateOut      (state)
  );
endmodule

// File: rtl/rxwake_checker.sv
module rxwake_checker #(
  parameter int MANT_W = 16,
  parameter int LDC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [MANT_W-1:0] mant,
  input logic [LDC_W-1:0]  ldc,
  input logic              syncValid,
  input logic              rxEnable,
  input logic              wakePulse,
  input logic [1:0]        state
);
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  assert_disable_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!rxEnable && state == 2'd0));

  assert_rise_at_wake_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEnable) |-> wakePulse);

  assert_receive_after_sync_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == 2'd2 && $past(state) != 2'd2) |-> $past(syncValid));

  assert_bad_cfg_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (ldc == '0 || mant == '0) && state == 2'd0) |=> state == 2'd0);

  assert_rx_state_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable == (state != 2'd0));
endmodule

bind rxwake_top rxwake_checker #(.MANT_W(MANT_W), .LDC_W(LDC_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .mant      (mant),
  .ldc       (ldc),
  .syncValid (syncValid),
  .rxEnable  (rxEnable),
  .wakePulse (wakePulse),
  .state     (state)
);

// File: tb/rxwake_top_tb.sv
module rxwake_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  rExp = '0;
  logic [15:0] mant = '0;
  logic [7:0]  ldc = '0;
  logic        preambleValid = 1'b0;
  logic        syncValid = 1'b0;
  logic        rxEnable, wakePulse;
  logic [1:0]  state;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  rxwake_top u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .rExp(rExp),
    .mant(mant), .ldc(ldc), .preambleValid(preambleValid),
    .syncValid(syncValid), .rxEnable(rxEnable), .wakePulse(wakePulse),
    .state(state)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) doTick();
  endtask

  task automatic pulsePre();
    @(negedge clk) preambleValid = 1'b1;
    @(negedge clk) preambleValid = 1'b0;
  endtask

  task automatic pulseSync();
    @(negedge clk) syncValid = 1'b1;
    @(negedge clk) syncValid = 1'b0;
  endtask

  task automatic restart(input int r, input int m, input int l);
    @(negedge clk) enable = 1'b0;
    rExp = 3'(r); mant = 16'(m); ldc = 8'(l);
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R9 reset rxEnable", int'(rxEnable), 0);
    check("R9 reset state", int'(state), 0);
    check("R8 reset wakePulse", int'(wakePulse), 0);
  endtask

  task automatic testWakeAndListen();
    restart(0, 2, 1);                      // P=8, W=4
    ticks(7);
    check("R1 asleep before boundary", int'(rxEnable), 0);
    doTick();
    check("R1 rx on at boundary", int'(rxEnable), 1);
    check("R1 state LISTEN", int'(state), 1);
    check("R8 wake pulse at boundary", int'(wakePulse), 1);
    @(negedge clk);
    check("R8 wake pulse one clock", int'(wakePulse), 0);
    ticks(3);
    check("R2 still listening", int'(state), 1);
    doTick();
    check("R2 back to sleep", int'(state), 0);
    check("R9 rx off with sleep", int'(rxEnable), 0);
    ticks(3);
    check("R2 sleeps until boundary", int'(rxEnable), 0);
    doTick();
    check("R1 next period wake", int'(state), 1);
  endtask

  task automatic testSyncNoPreamble();
    restart(0, 2, 1);
    ticks(8);
    pulseSync();
    check("R3 lone sync ignored", int'(state), 1);
    ticks(3);
    check("R3 lone sync ignored window", int'(state), 1);
    doTick();
    check("R3 lone sync no extension", int'(state), 0);
  endtask

  task automatic testExtend();
    restart(0, 2, 1);
    ticks(8);
    ticks(2);
    pulsePre();
    pulseSync();
    check("R3 receive entered", int'(state), 2);
    check("R9 rx on in receive", int'(rxEnable), 1);
    ticks(3);
    check("R3 extension holds", int'(state), 2);
    doTick();
    check("R3 extension ends after W", int'(state), 0);
  endtask

  task automatic testExponent();
    restart(1, 2, 1);                      // P=16, W=8
    ticks(15);
    check("R4 no wake at tick 15", int'(rxEnable), 0);
    doTick();
    check("R4 wake at tick 16", int'(rxEnable), 1);
    ticks(7);
    check("R4 listen spans 8 ticks", int'(rxEnable), 1);
    doTick();
    check("R4 listen ends at 8", int'(rxEnable), 0);
  endtask

  task automatic testOverrun();
    restart(0, 2, 2);                      // P=8, W=8
    ticks(9);
    pulsePre();
    pulseSync();
    ticks(6);
    check("R5 receiving before boundary", int'(state), 2);
    doTick();                              // tick 16: boundary in RECEIVE
    check("R8 pulse on skipped boundary", int'(wakePulse), 1);
    check("R5 boundary skipped", int'(state), 2);
    doTick();
    check("R5 extension end", int'(state), 0);
    ticks(6);
    check("R5 skipped wake not queued", int'(rxEnable), 0);
    doTick();                              // tick 24
    check("R5 grid kept across extension", int'(state), 1);
  endtask

  task automatic testZeroCfg();
    int seen;
    restart(0, 0, 1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin doTick(); seen += int'(rxEnable); end
    check("R6 mant zero keeps rx off", seen, 0);
    restart(0, 2, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin doTick(); seen += int'(rxEnable); end
    check("R6 ldc zero keeps rx off", seen, 0);
  endtask

  task automatic testDisable();
    restart(0, 2, 1);
    ticks(8);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check("R7 disable forces sleep", int'(state), 0);
    check("R7 disable drops rx", int'(rxEnable), 0);
    enable = 1'b1;
    ticks(7);
    check("R7 period restarted", int'(rxEnable), 0);
    doTick();
    check("R7 wake P ticks after enable", int'(rxEnable), 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testWakeAndListen();
    testSyncNoPreamble();
    testExtend();
    testExponent();
    testOverrun();
    testZeroCfg();
    testDisable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule